// File: doc/BRIEF.md
# Interrupt Response Cycle Sequencer

This block produces the bus activity that an 8-bit processor core performs when it takes an interrupt. While it is idle, it samples a non-maskable request and a maskable request on each rising clock edge. When one of them is present, it latches the program counter, the stack pointer and the vector page. It then plays out a fixed recipe of machine cycles, where one T-state equals one clock. A non-maskable request runs a 5-T opcode-fetch-type cycle and then pushes the program counter. A maskable request behaves according to the selected mode:

- **Mode 0:** a short acknowledge only.
- **Mode 1:** an acknowledge, a push, and a jump to a fixed restart address.
- **Mode 2:** an acknowledge, a push, and a two-byte read from a vector table.

When the last T-state ends, the block pulses `done` for one clock and presents the new program counter and stack pointer. The surrounding core commits these values. Executing an opcode supplied on the bus in mode 0 is left to the core.

All bus strobes are active high. They stay asserted for every T-state of their machine cycle. Read data is taken on the last T-state of a read or acknowledge cycle.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset, `m1`, `mreq`, `iorq`, `rd`, `wr` and `done` are low, and `new_pc` and `new_sp` are zero. No strobe is high while the block is idle.
- R2: A non-maskable response lasts 11 T-states, made up of:
  - 5 T-states with `m1`, `mreq` and `rd` high and `addr` equal to the latched PC;
  - two 3-T writes;
  - `new_pc` = 0x0066.
- R3: A mode 1 response lasts 13 T-states, made up of:
  - a 7-T acknowledge with `m1` and `iorq` high, `mreq` low and `addr` = PC;
  - two 3-T writes;
  - `new_pc` = 0x0038.
- R4: A mode 2 response lasts 19 T-states, made up of:
  - a 7-T acknowledge;
  - two 3-T writes;
  - two 3-T reads, first at {vector page, acknowledged byte with bit 0 cleared} and then at that address with bit 0 set.

  The first byte read is the low byte of `new_pc` and the second is the high byte.
- R5: A mode 0 response is a 2-T acknowledge with no memory cycle. `new_pc` and `new_sp` equal the latched PC and SP.
- R6: The stack pushes write PC[15:8] to SP-1 and then PC[7:0] to SP-2, with 16-bit wraparound, and `new_sp` = SP-2. `rd` and `wr` are never high together.
- R7: When both requests are seen on the same edge, the non-maskable response runs.
- R8: `int_mode` encodes 0 = mode 0, 1 = mode 1, 2 = mode 2, and the value 3 behaves as mode 2.
- R9: `done` is high for exactly one clock, in the cycle right after the last T-state. `new_pc` and `new_sp` take their values then and hold them until the next `done`.
- R10: Requests that arrive while a response is running have no effect on it and start nothing afterwards once they have been withdrawn.
- R11: A request seen on a rising edge while idle makes the first T-state begin in the very next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| int_req | input | 1 | Maskable interrupt request |
| int_mode | input | 2 | Maskable response mode (3 acts as 2) |
| vec_page | input | 8 | High byte of the vector table address |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter |
| din | input | 8 | Bus read data |
| addr | output | 16 | Address bus |
| dout | output | 8 | Bus write data |
| m1 | output | 1 | Opcode-fetch / acknowledge marker |
| mreq | output | 1 | Memory request |
| iorq | output | 1 | I/O request (acknowledge) |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| new_pc | output | 16 | Program counter to commit |
| new_sp | output | 16 | Stack pointer to commit |
| done | output | 1 | One-clock completion pulse |

## Verification
The case that is hardest to reach from the ports is a second request that lands in the middle of a running response. The sequencer must neither restart nor switch recipes. The bench pulses a non-maskable request partway through a mode 1 response. It then checks that the T-state count, the pushed bytes and the restart target are still those of mode 1, and that nothing follows.

Two other corners are reached by loading the inputs directly:
- a stack pointer of 0x0001 makes the push wrap to 0xFFFF;
- an odd acknowledged byte shows that bit 0 of the table address is forced low.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

  localparam int DW     = 8;
  localparam int AW     = 2 * DW;
  localparam int MC_MAX = 7;
  localparam int IW     = $clog2(MC_MAX + 1);
  localparam int TW     = 3;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_FETCH,
    CY_ACK,
    CY_MRD,
    CY_MWR
  } cyc_e;

  typedef enum logic [1:0] {
    RK_NMI,
    RK_BUS,
    RK_RST,
    RK_TBL
  } kind_e;

  typedef struct packed {
    cyc_e          cyc;
    logic [TW-1:0] len;
  } step_t;

  // Machine-cycle recipe: type and length of step i for a response kind.
  function automatic step_t recipe_step(kind_e k, logic [IW-1:0] i);
    step_t s;
    s = '{CY_IDLE, '0};
    case (k)
      RK_NMI: begin
        if (i == 0)                s = '{CY_FETCH, TW'(5)};
        else if (i == 1 || i == 2) s = '{CY_MWR,   TW'(3)};
      end
      RK_BUS: begin
        if (i == 0)                s = '{CY_ACK,   TW'(2)};
      end
      RK_RST: begin
        if (i == 0)                s = '{CY_ACK,   TW'(7)};
        else if (i == 1 || i == 2) s = '{CY_MWR,   TW'(3)};
      end
      RK_TBL: begin
        if (i == 0)                s = '{CY_ACK,   TW'(7)};
        else if (i == 1 || i == 2) s = '{CY_MWR,   TW'(3)};
        else if (i == 3 || i == 4) s = '{CY_MRD,   TW'(3)};
      end
      default: s = '{CY_IDLE, '0};
    endcase
    return s;
  endfunction

  // Stack slot for push number n (1 = first push).
  function automatic logic [AW-1:0] push_addr(logic [AW-1:0] sp, logic [1:0] n);
    return sp - AW'(n);
  endfunction

  // Byte pushed in push number n: high byte first.
  function automatic logic [DW-1:0] push_byte(logic [AW-1:0] pc, logic [1:0] n);
    return (n == 2'd1) ? pc[AW-1:DW] : pc[DW-1:0];
  endfunction

  // Vector table entry address; hi_sel picks the second byte.
  function automatic logic [AW-1:0] table_addr(logic [DW-1:0] page,
                                               logic [DW-1:0] vec,
                                               logic          hi_sel);
    return {page, vec[DW-1:1], hi_sel};
  endfunction

endpackage

// File: rtl/irq_resp_arb.sv
module irq_resp_arb
  import irq_resp_pkg::*;
(
  input  logic       nmi_req,
  input  logic       int_req,
  input  logic [1:0] int_mode,
  output logic       req_any,
  output kind_e      kind
);

  always_comb begin
    req_any = nmi_req | int_req;
    if (nmi_req) begin
      kind = RK_NMI;
    end else begin
      case (int_mode)
        2'd0:    kind = RK_BUS;
        2'd1:    kind = RK_RST;
        default: kind = RK_TBL;
      endcase
    end
  end

endmodule

// File: rtl/irq_resp_steps.sv
module irq_resp_steps
  import irq_resp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  kind_e         kind,
  output logic          busy,
  output logic [IW-1:0] mc,
  output cyc_e          cyc,
  output logic          cyc_last,
  output logic          seq_end
);

  logic [TW-1:0] tcnt_q;
  logic [IW-1:0] mc_q;
  logic          busy_q;
  step_t         step_cur;
  step_t         step_nxt;

  always_comb begin
    step_cur = recipe_step(kind, mc_q);
    step_nxt = recipe_step(kind, mc_q + IW'(1));
    cyc_last = busy_q && (tcnt_q == step_cur.len - TW'(1));
    seq_end  = cyc_last &&
               ((step_nxt.cyc == CY_IDLE) || (mc_q == IW'(MC_MAX - 1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
      mc_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
      mc_q   <= '0;
    end else if (busy_q) begin
      if (seq_end) begin
        busy_q <= 1'b0;
        tcnt_q <= '0;
        mc_q   <= '0;
      end else if (cyc_last) begin
        tcnt_q <= '0;
        mc_q   <= mc_q + IW'(1);
      end else begin
        tcnt_q <= tcnt_q + TW'(1);
      end
    end
  end

  assign busy = busy_q;
  assign mc   = mc_q;
  assign cyc  = busy_q ? step_cur.cyc : CY_IDLE;

endmodule

// File: rtl/irq_resp_bus.sv
module irq_resp_bus
  import irq_resp_pkg::*;
(
  input  cyc_e          cyc,
  input  logic [IW-1:0] mc,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] sp_q,
  input  logic [DW-1:0] page_q,
  input  logic [DW-1:0] vec_q,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          m1,
  output logic          mreq,
  output logic          iorq,
  output logic          rd,
  output logic          wr
);

  logic [1:0] push_n;

  always_comb begin
    push_n = (mc == IW'(1)) ? 2'd1 : 2'd2;
    addr   = '0;
    dout   = '0;
    m1     = 1'b0;
    mreq   = 1'b0;
    iorq   = 1'b0;
    rd     = 1'b0;
    wr     = 1'b0;
    case (cyc)
      CY_FETCH: begin
        addr = pc_q;
        m1   = 1'b1;
        mreq = 1'b1;
        rd   = 1'b1;
      end
      CY_ACK: begin
        addr = pc_q;
        m1   = 1'b1;
        iorq = 1'b1;
      end
      CY_MWR: begin
        addr = push_addr(sp_q, push_n);
        dout = push_byte(pc_q, push_n);
        mreq = 1'b1;
        wr   = 1'b1;
      end
      CY_MRD: begin
        addr = table_addr(page_q, vec_q, mc == IW'(4));
        mreq = 1'b1;
        rd   = 1'b1;
      end
      default: begin
        addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
  import irq_resp_pkg::*;
#(
  parameter logic [15:0] NMI_TARGET = 16'h0066,
  parameter logic [15:0] RST_TARGET = 16'h0038
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        int_req,
  input  logic [1:0]  int_mode,
  input  logic [7:0]  vec_page,
  input  logic [15:0] sp_in,
  input  logic [15:0] pc_in,
  input  logic [7:0]  din,
  output logic [15:0] addr,
  output logic [7:0]  dout,
  output logic        m1,
  output logic        mreq,
  output logic        iorq,
  output logic        rd,
  output logic        wr,
  output logic [15:0] new_pc,
  output logic [15:0] new_sp,
  output logic        done
);

  logic          req_any;
  kind_e         kind_sel;
  kind_e         kind_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] sp_q;
  logic [DW-1:0] page_q;
  logic [DW-1:0] vec_q;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] new_pc_q;
  logic [AW-1:0] new_sp_q;
  logic          done_q;

  // Named internal events for the checker.
  logic          busy_w;
  logic          start_w;
  logic          seq_end_w;
  logic          cyc_last_w;
  logic [IW-1:0] mc_w;
  cyc_e          cyc_w;
  logic [1:0]    kind_bits;

  irq_resp_arb u_arb (
    .nmi_req  (nmi_req),
    .int_req  (int_req),
    .int_mode (int_mode),
    .req_any  (req_any),
    .kind     (kind_sel)
  );

  assign start_w   = req_any && !busy_w;
  assign kind_bits = kind_q;

  irq_resp_steps u_steps (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .kind     (kind_q),
    .busy     (busy_w),
    .mc       (mc_w),
    .cyc      (cyc_w),
    .cyc_last (cyc_last_w),
    .seq_end  (seq_end_w)
  );

  irq_resp_bus u_bus (
    .cyc    (cyc_w),
    .mc     (mc_w),
    .pc_q   (pc_q),
    .sp_q   (sp_q),
    .page_q (page_q),
    .vec_q  (vec_q),
    .addr   (addr),
    .dout   (dout),
    .m1     (m1),
    .mreq   (mreq),
    .iorq   (iorq),
    .rd     (rd),
    .wr     (wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= RK_NMI;
      pc_q   <= '0;
      sp_q   <= '0;
      page_q <= '0;
    end else if (start_w) begin
      kind_q <= kind_sel;
      pc_q   <= pc_in;
      sp_q   <= sp_in;
      page_q <= vec_page;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      lo_q  <= '0;
    end else if (cyc_last_w) begin
      if (cyc_w == CY_ACK) vec_q <= din;
      if (cyc_w == CY_MRD && mc_w == IW'(3)) lo_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pc_q <= '0;
      new_sp_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= seq_end_w;
      if (seq_end_w) begin
        case (kind_q)
          RK_NMI:  new_pc_q <= NMI_TARGET;
          RK_BUS:  new_pc_q <= pc_q;
          RK_RST:  new_pc_q <= RST_TARGET;
          default: new_pc_q <= {din, lo_q};
        endcase
        new_sp_q <= (kind_q == RK_BUS) ? sp_q : push_addr(sp_q, 2'd2);
      end
    end
  end

  assign new_pc = new_pc_q;
  assign new_sp = new_sp_q;
  assign done   = done_q;

endmodule

// File: rtl/irq_resp_chk.sv
module irq_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_w,
  input logic       start_w,
  input logic       done,
  input logic       m1,
  input logic       mreq,
  input logic       iorq,
  input logic       rd,
  input logic       wr,
  input logic [1:0] kind_bits
);

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !(m1 || mreq || iorq || rd || wr)); // R1

  AST_MREQ_IORQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq && iorq)); // R3

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr)); // R6

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy_w) && !busy_w)); // R9

  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> $stable(kind_bits)); // R10

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> busy_w); // R11

endmodule

bind irq_resp_seq irq_resp_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_w    (busy_w),
  .start_w   (start_w),
  .done      (done),
  .m1        (m1),
  .mreq      (mreq),
  .iorq      (iorq),
  .rd        (rd),
  .wr        (wr),
  .kind_bits (kind_bits)
);

// File: tb/irq_resp_seq_tb.sv
module irq_resp_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0;
  logic        int_req = 1'b0;
  logic [1:0]  int_mode = 2'd0;
  logic [7:0]  vec_page = 8'h00;
  logic [15:0] sp_in = 16'h0;
  logic [15:0] pc_in = 16'h0;
  logic [7:0]  din;
  logic [15:0] addr;
  logic [7:0]  dout;
  logic        m1, mreq, iorq, rd, wr, done;
  logic [15:0] new_pc, new_sp;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] cur_vec = 8'h00;
  logic [7:0] cur_lo  = 8'h00;
  logic [7:0] cur_hi  = 8'h00;

  always #2.5 clk = ~clk;

  irq_resp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .int_req(int_req),
    .int_mode(int_mode), .vec_page(vec_page), .sp_in(sp_in), .pc_in(pc_in),
    .din(din), .addr(addr), .dout(dout), .m1(m1), .mreq(mreq), .iorq(iorq),
    .rd(rd), .wr(wr), .new_pc(new_pc), .new_sp(new_sp), .done(done)
  );

  // Bus responder: acknowledge yields the vector byte, table reads by address bit 0.
  always_comb begin
    if (m1 && iorq)              din = cur_vec;
    else if (mreq && rd && !m1)  din = addr[0] ? cur_hi : cur_lo;
    else                         din = 8'h00;
  end

  typedef struct packed {
    logic        nmi;
    logic        intr;
    logic [1:0]  mode;
    logic [7:0]  page;
    logic [15:0] sp;
    logic [15:0] pc;
    logic [7:0]  vec;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [1:0]  ekind;   // 0 nmi, 1 mode0, 2 mode1, 3 mode2
    logic [15:0] exp_pc;
    logic [15:0] exp_sp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 8'h12, 16'h8000, 16'h1234, 8'hFF, 8'h00, 8'h00, 2'd0, 16'h0066, 16'h7FFE},
    '{1'b0, 1'b1, 2'd0, 8'h00, 16'h4000, 16'h0200, 8'hC7, 8'h00, 8'h00, 2'd1, 16'h0200, 16'h4000},
    '{1'b0, 1'b1, 2'd1, 8'h00, 16'hF000, 16'hABCD, 8'h00, 8'h00, 8'h00, 2'd2, 16'h0038, 16'hEFFE},
    '{1'b0, 1'b1, 2'd2, 8'h3A, 16'h2000, 16'h0F0F, 8'h20, 8'h78, 8'h56, 2'd3, 16'h5678, 16'h1FFE},
    '{1'b0, 1'b1, 2'd2, 8'h3A, 16'h2222, 16'h0101, 8'h21, 8'h11, 8'h99, 2'd3, 16'h9911, 16'h2220},
    '{1'b1, 1'b1, 2'd2, 8'h3A, 16'h9000, 16'h4321, 8'h20, 8'h78, 8'h56, 2'd0, 16'h0066, 16'h8FFE},
    '{1'b0, 1'b1, 2'd3, 8'h80, 16'h6000, 16'h0777, 8'h44, 8'hEF, 8'hBE, 2'd3, 16'hBEEF, 16'h5FFE},
    '{1'b0, 1'b1, 2'd1, 8'h00, 16'h0001, 16'h5AA5, 8'h00, 8'h00, 8'h00, 2'd2, 16'h0038, 16'hFFFF}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string kind_tag(logic [1:0] k);
    case (k)
      2'd0:    return "R2";
      2'd1:    return "R5";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  // Expected T-state counts per cycle class: fetch, ack, read, write.
  function automatic logic [31:0] exp_counts(logic [1:0] k);
    case (k)
      2'd0:    return {8'd5, 8'd0, 8'd0, 8'd6};
      2'd1:    return {8'd0, 8'd2, 8'd0, 8'd0};
      2'd2:    return {8'd0, 8'd7, 8'd0, 8'd6};
      default: return {8'd0, 8'd7, 8'd6, 8'd6};
    endcase
  endfunction

  // Runs one response; inject >= 0 pulses nmi_req at that T-state.
  task automatic run_vec(input vec_t v, input string tg, input int inject);
    int nf = 0, na = 0, nr = 0, nw = 0, nt = 0;
    int nwr = 0, nrd = 0;
    logic [15:0] wa [2];
    logic [7:0]  wd [2];
    logic [15:0] ra [2];
    logic prev_wr = 1'b0, prev_rd = 1'b0;
    logic [15:0] prev_a = 16'h0;
    logic [15:0] tb_lo;
    string rt;
    for (int j = 0; j < 2; j++) begin wa[j] = 0; wd[j] = 0; ra[j] = 0; end
    rt = kind_tag(v.ekind);
    @(negedge clk);
    nmi_req  = v.nmi;
    int_req  = v.intr;
    int_mode = v.mode;
    vec_page = v.page;
    sp_in    = v.sp;
    pc_in    = v.pc;
    cur_vec  = v.vec;
    cur_lo   = v.lo;
    cur_hi   = v.hi;
    @(negedge clk);
    nmi_req = 1'b0;
    int_req = 1'b0;
    chk("R11", "strobe in first cycle after request", 32'(m1 | mreq | iorq), 32'd1);
    while ((m1 | mreq | iorq | rd | wr) && nt < 40) begin
      if (inject >= 0 && nt == inject)     nmi_req = 1'b1;
      if (inject >= 0 && nt == inject + 1) nmi_req = 1'b0;
      if (done) chk("R9", "done during bus activity", 32'd1, 32'd0);
      if (m1 && mreq && rd) begin
        nf++;
        chk(rt, "fetch-type address", 32'(addr), 32'(v.pc));
      end else if (m1 && iorq) begin
        na++;
        chk(rt, "acknowledge address", 32'(addr), 32'(v.pc));
      end else if (mreq && rd) begin
        nr++;
        if ((!prev_rd || addr != prev_a) && nrd < 2) begin ra[nrd] = addr; nrd++; end
      end else if (mreq && wr) begin
        nw++;
        if ((!prev_wr || addr != prev_a) && nwr < 2) begin
          wa[nwr] = addr; wd[nwr] = dout; nwr++;
        end
      end
      prev_wr = wr; prev_rd = rd && !m1; prev_a = addr;
      nt++;
      @(negedge clk);
    end
    nmi_req = 1'b0;
    chk(rt, "cycle class counts", {8'(nf), 8'(na), 8'(nr), 8'(nw)}, exp_counts(v.ekind));
    chk(rt, "total T-states", 32'(nt),
        32'(exp_counts(v.ekind)[31:24] + exp_counts(v.ekind)[23:16] +
            exp_counts(v.ekind)[15:8] + exp_counts(v.ekind)[7:0]));
    if (v.ekind != 2'd1) begin
      chk("R6", "first push address", 32'(wa[0]), 32'(16'(v.sp - 16'd1)));
      chk("R6", "first push data", 32'(wd[0]), 32'(v.pc[15:8]));
      chk("R6", "second push address", 32'(wa[1]), 32'(16'(v.sp - 16'd2)));
      chk("R6", "second push data", 32'(wd[1]), 32'(v.pc[7:0]));
    end
    if (v.ekind == 2'd3) begin
      tb_lo = {v.page, v.vec[7:1], 1'b0};
      chk("R4", "table low read address", 32'(ra[0]), 32'(tb_lo));
      chk("R4", "table high read address", 32'(ra[1]), 32'(tb_lo | 16'h1));
    end
    chk("R9", "done after last T-state", 32'(done), 32'd1);
    chk(tg, "new_pc", 32'(new_pc), 32'(v.exp_pc));
    chk(v.ekind == 2'd1 ? "R5" : "R6", "new_sp", 32'(new_sp), 32'(v.exp_sp));
    @(negedge clk);
    chk("R9", "done is one clock wide", 32'(done), 32'd0);
    chk("R9", "new_pc held", 32'(new_pc), 32'(v.exp_pc));
    chk("R10", "no further activity", 32'(m1 | mreq | iorq | rd | wr), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "strobes in reset", 32'({m1, mreq, iorq, rd, wr}), 32'd0);
    chk("R1", "done in reset", 32'(done), 32'd0);
    chk("R1", "new_pc in reset", 32'(new_pc), 32'd0);
    chk("R1", "new_sp in reset", 32'(new_sp), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle strobes after reset", 32'({m1, mreq, iorq, rd, wr}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      tg = kind_tag(VECS[i].ekind);
      if (i == 5) tg = "R7";
      if (i == 6) tg = "R8";
      run_vec(VECS[i], tg, -1);
      repeat (2) @(negedge clk);
    end

    // R10: non-maskable pulse in the middle of a mode 1 response
    run_vec(VECS[2], "R10", 5);
    repeat (3) @(negedge clk);
    chk("R10", "quiet after ignored request", 32'({m1, mreq, iorq, rd, wr, done}), 32'd0);
    chk("R10", "new_pc still restart target", 32'(new_pc), 32'h0038);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule